// File: doc/BRIEF.md
# Noise and Triangle Wave Generator for a Converter Channel

This block sits in front of one output channel of a digital-to-analog converter. Each accepted trigger advances either a pseudo-random noise source or a triangle counter. The generated value is added to a 12-bit base value taken from the channel's holding register. The saturated sum is held in a register, ready for transfer to the converter's output register.

A 2-bit mode input selects what is added: nothing, masked noise or the triangle. A 4-bit code has one meaning per mode. In noise mode it sets how many low bits of the noise source pass through. In triangle mode it sets the peak of the triangle. A trigger is accepted only when the channel is enabled, triggering is enabled and the trigger pulse is high. Clearing the channel enable returns both generators to their starting state.

Top module: `wavegen_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_val` is 0. After reset the noise register holds 0xAAA, the triangle count is 0 and the triangle direction is up.
- R2: With `mode` = 00 and the channel enabled, `out_val` equals `base_val`. Triggers advance neither generator, and a later switch to noise still shows the seed.
- R3: With `trig_en` = 0, `out_val` equals `base_val` in every mode, and trigger pulses advance neither generator.
- R4: With `mode` = 01, the generated value is the noise register ANDed with a mask. For code n from 0 to 10, the mask keeps bits [n:0] and forces the bits above them to zero.
- R5: The noise register is a 12-bit left-shifting LFSR. Its feedback bit is the XOR of bits 11, 5, 3 and 0, and it enters at bit 0. It steps once per accepted trigger in noise mode and is never zero.
- R6: With `mode` = 10 or 11, the generated value is a counter with peak P = 2^(n+1)-1. Each accepted trigger moves it one step up to P and then one step down to 0, and the cycle repeats. With code 1 and a start at 0, the values after successive triggers are 1,2,3,2,1,0,1.
- R7: Any code of 11 or above gives a mask of all 12 bits in noise mode and a triangle peak of 4095.
- R8: `out_val` is `base_val` plus the generated value, clamped at 4095.
- R9: In every cycle after one with `chan_en` low, `out_val` is 0. The noise register returns to 0xAAA and the triangle returns to count 0 with direction up.
- R10: `out_val` is registered. It reflects the inputs and the generator state of the previous cycle. A trigger therefore shows at the output two clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; low clears both generators |
| trig_en | input | 1 | Trigger enable; wave generation needs this high |
| trig_pulse | input | 1 | Trigger event, one cycle per step |
| mode | input | 2 | 00 none, 01 noise, 1x triangle |
| amp_code | input | 4 | Noise mask width or triangle peak code |
| base_val | input | 12 | Base value from the holding register |
| out_val | output | 12 | Saturated base plus generated value |

## Verification
Noise mode is first tried with a base of zero and no trigger, once for every code. The fixed seed then exposes each mask width on its own, and this separates off-by-one mask decoding from saturation at code 11. A run of triggers in noise mode checks the feedback taps. Mode 00 and trigger-disabled runs are followed by a switch back to noise, which shows whether an ignored trigger disturbed the register. Triangle runs with a small peak, and then with the full 4095 peak, separate the turnaround points from the ramps. A large base with a full mask checks the clamp. Long constrained-random runs then mix modes, codes, base values, enable drops and trigger gaps against a bench model.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;
  localparam int WG_WIDTH  = 12;
  localparam int WG_CODE_W = 4;

  typedef enum logic [1:0] {
    WG_NONE    = 2'b00,
    WG_NOISE   = 2'b01,
    WG_TRI     = 2'b10,
    WG_TRI_ALT = 2'b11
  } wg_mode_e;

  function automatic logic is_tri(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic is_noise(input logic [1:0] m);
    return (m == WG_NOISE);
  endfunction
endpackage

// File: rtl/wavegen_mask_dec.sv
module wavegen_mask_dec #(
  parameter int WIDTH  = 12,
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  output logic [WIDTH-1:0]  mask
);
  // bit i is kept when code >= i; codes at or above WIDTH-1 keep every bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign mask[i] = 1'b1;
    end else begin : g_up
      assign mask[i] = (32'(code) >= i);
    end
  end
endmodule

// File: rtl/wavegen_lfsr.sv
module wavegen_lfsr #(
  parameter int               WIDTH = 12,
  parameter logic [WIDTH-1:0] SEED  = 12'hAAA,
  parameter logic [WIDTH-1:0] TAPS  = 12'h829
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [WIDTH-1:0] state
);
  logic             fb;
  logic [WIDTH-1:0] nxt;

  always_comb begin
    fb  = ^(state & TAPS);
    nxt = {state[WIDTH-2:0], fb};
  end

  always_ff @(posedge clk) begin
    if (rst || clear) state <= SEED;
    else if (step)    state <= nxt;
  end
endmodule

// File: rtl/wavegen_tri.sv
module wavegen_tri #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [WIDTH-1:0] peak,
  output logic [WIDTH-1:0] count,
  output logic             going_up
);
  logic [WIDTH-1:0] cnt_n;
  logic             up_n;

  always_comb begin
    cnt_n = count;
    up_n  = going_up;
    if (going_up) begin
      if (count >= peak) begin
        cnt_n = count - 1'b1;
        up_n  = 1'b0;
      end else begin
        cnt_n = count + 1'b1;
      end
    end else begin
      if (count == '0) begin
        cnt_n = {{(WIDTH-1){1'b0}}, 1'b1};
        up_n  = 1'b1;
      end else begin
        cnt_n = count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count    <= '0;
      going_up <= 1'b1;
    end else if (step) begin
      count    <= cnt_n;
      going_up <= up_n;
    end
  end
endmodule

// File: rtl/wavegen_top.sv
module wavegen_top
  import wavegen_pkg::*;
#(
  parameter int               WIDTH  = WG_WIDTH,
  parameter int               CODE_W = WG_CODE_W,
  parameter logic [WIDTH-1:0] SEED   = 12'hAAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_en,
  input  logic              trig_en,
  input  logic              trig_pulse,
  input  logic [1:0]        mode,
  input  logic [CODE_W-1:0] amp_code,
  input  logic [WIDTH-1:0]  base_val,
  output logic [WIDTH-1:0]  out_val
);
  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};

  logic             accept, noise_step, tri_step, clear;
  logic [WIDTH-1:0] mask, lfsr_q, tri_cnt, gen;
  logic             tri_up;
  logic [WIDTH:0]   sum;

  assign accept     = chan_en & trig_en & trig_pulse;
  assign noise_step = accept & is_noise(mode);
  assign tri_step   = accept & is_tri(mode);
  assign clear      = ~chan_en;

  wavegen_mask_dec #(.WIDTH(WIDTH), .CODE_W(CODE_W)) u_mask (
    .code(amp_code), .mask(mask)
  );

  wavegen_lfsr #(.WIDTH(WIDTH), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .clear(clear), .step(noise_step), .state(lfsr_q)
  );

  wavegen_tri #(.WIDTH(WIDTH)) u_tri (
    .clk(clk), .rst(rst), .clear(clear), .step(tri_step), .peak(mask),
    .count(tri_cnt), .going_up(tri_up)
  );

  always_comb begin
    if (!trig_en)          gen = '0;
    else if (is_tri(mode)) gen = tri_cnt;
    else if (mode[0])      gen = lfsr_q & mask;
    else                   gen = '0;
    sum = {1'b0, base_val} + {1'b0, gen};
  end

  always_ff @(posedge clk) begin
    if (rst || !chan_en) out_val <= '0;
    else                 out_val <= sum[WIDTH] ? FULL : sum[WIDTH-1:0];
  end
endmodule

// File: rtl/wavegen_chk.sv
module wavegen_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             chan_en,
  input logic             trig_en,
  input logic             trig_pulse,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] base_val,
  input logic [WIDTH-1:0] out_val,
  input logic [WIDTH-1:0] lfsr_q,
  input logic [WIDTH-1:0] tri_cnt
);
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> out_val == '0); // R9

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0); // R5

  AST_NO_STRAY_STEP: assert property (@(posedge clk) disable iff (rst)
    (chan_en && !(trig_en && trig_pulse)) |=> ($stable(lfsr_q) && $stable(tri_cnt))); // R3

  AST_BASE_PASS: assert property (@(posedge clk) disable iff (rst)
    (chan_en && (mode == 2'b00 || !trig_en)) |=> out_val == $past(base_val)); // R2

  AST_TRI_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    chan_en |=> (tri_cnt == $past(tri_cnt) || tri_cnt == $past(tri_cnt) + 1'b1
                 || tri_cnt + 1'b1 == $past(tri_cnt))); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    chan_en |=> out_val >= $past(base_val)); // R8
endmodule

bind wavegen_top wavegen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .chan_en(chan_en), .trig_en(trig_en),
  .trig_pulse(trig_pulse), .mode(mode), .base_val(base_val),
  .out_val(out_val), .lfsr_q(lfsr_q), .tri_cnt(tri_cnt)
);

// File: tb/wavegen_top_test.sv
`timescale 1ns/100ps
module wavegen_top_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        chan_en = 0, trig_en = 0, trig_pulse = 0;
  logic [1:0]  mode = 0;
  logic [3:0]  amp_code = 0;
  logic [11:0] base_val = 0;
  logic [11:0] out_val;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [11:0] m_lfsr = 12'hAAA, m_cnt = 0;
  logic        m_up = 1;

  always #2.5 clk = ~clk;

  wavegen_top uut (
    .clk(clk), .rst(rst), .chan_en(chan_en), .trig_en(trig_en),
    .trig_pulse(trig_pulse), .mode(mode), .amp_code(amp_code),
    .base_val(base_val), .out_val(out_val)
  );

  function automatic logic [11:0] f_mask(input logic [3:0] c);
    if (c >= 4'd11) return 12'hFFF;
    return 12'((13'd1 << (c + 1)) - 1);
  endfunction

  function automatic logic [11:0] f_expect();
    logic [11:0] g;
    logic [12:0] s;
    if (rst || !chan_en) return 12'd0;
    if (!trig_en) g = 0;
    else if (mode[1]) g = m_cnt;
    else if (mode == 2'b01) g = m_lfsr & f_mask(amp_code);
    else g = 0;
    s = {1'b0, base_val} + {1'b0, g};
    return s[12] ? 12'hFFF : s[11:0];
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit chk, input string req);
    logic [11:0] exp, nl, nc, pk;
    logic nu;
    bit acc;
    exp = f_expect();
    nl = m_lfsr; nc = m_cnt; nu = m_up;
    acc = chan_en && trig_en && trig_pulse;
    if (rst || !chan_en) begin
      nl = 12'hAAA; nc = 0; nu = 1;
    end else if (acc && mode == 2'b01) begin
      nl = {m_lfsr[10:0], m_lfsr[11] ^ m_lfsr[5] ^ m_lfsr[3] ^ m_lfsr[0]};
    end else if (acc && mode[1]) begin
      pk = f_mask(amp_code);
      if (m_up) begin
        if (m_cnt >= pk) begin nc = m_cnt - 1; nu = 0; end
        else nc = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin nc = 1; nu = 1; end
        else nc = m_cnt - 1;
      end
    end
    @(posedge clk); #1;
    m_lfsr = nl; m_cnt = nc; m_up = nu;
    if (chk) check(req, out_val, exp);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    // R1 reset
    repeat (3) cyc(0, "R1");
    check("R1 in reset", out_val, 0);
    rst = 0;
    chan_en = 1; trig_en = 1; mode = 2'b01; amp_code = 4'd11; base_val = 0;
    cyc(1, "R1 first cycle");
    cyc(1, "R1 seed visible");
    check("R1 seed literal", out_val, 12'hAAA);
    // R4 masks per code
    for (int c = 0; c <= 10; c++) begin
      amp_code = 4'(c);
      cyc(1, "R4");
      check("R4 mask literal", out_val, 12'hAAA & 12'((13'd1 << (c + 1)) - 1));
    end
    // R7 codes at 11 and above
    for (int c = 11; c <= 15; c++) begin
      amp_code = 4'(c);
      cyc(1, "R7 noise");
      check("R7 noise full", out_val, 12'hAAA);
    end
    // R5 LFSR stepping
    amp_code = 4'd15;
    for (int i = 0; i < 20; i++) begin
      trig_pulse = 1; cyc(1, "R5");
      trig_pulse = 0; cyc(1, "R5 step value");
    end
    // R2 mode 00 ignores triggers
    mode = 2'b00; base_val = 12'd321;
    for (int i = 0; i < 5; i++) begin
      trig_pulse = 1; cyc(1, "R2");
    end
    trig_pulse = 0; cyc(1, "R2");
    check("R2 base pass", out_val, 12'd321);
    mode = 2'b01; base_val = 0;
    cyc(1, "R2 lfsr unchanged");
    cyc(1, "R2 lfsr unchanged");
    // R3 trigger disabled
    trig_en = 0; base_val = 12'd77;
    for (int i = 0; i < 5; i++) begin
      trig_pulse = 1; cyc(1, "R3");
    end
    trig_pulse = 0; cyc(1, "R3");
    check("R3 base only", out_val, 12'd77);
    trig_en = 1; base_val = 0; cyc(1, "R3 lfsr unchanged"); cyc(1, "R3 lfsr unchanged");
    // R9 enable drop restores seed
    chan_en = 0; cyc(1, "R9"); cyc(1, "R9");
    check("R9 zero", out_val, 0);
    chan_en = 1; cyc(1, "R9"); cyc(1, "R9 seed");
    check("R9 seed literal", out_val, 12'hAAA);
    // R6 small triangle
    mode = 2'b10; amp_code = 4'd1;
    begin
      logic [11:0] seq [7] = '{1, 2, 3, 2, 1, 0, 1};
      for (int i = 0; i < 7; i++) begin
        trig_pulse = 1; cyc(1, "R6");
        trig_pulse = 0; cyc(1, "R6");
        check("R6 sequence", out_val, seq[i]);
      end
    end
    // R7 full triangle peak
    chan_en = 0; cyc(1, "R9"); chan_en = 1;
    mode = 2'b11; amp_code = 4'd12; trig_pulse = 1;
    for (int i = 0; i < 4095; i++) cyc(0, "R7");
    trig_pulse = 0; cyc(1, "R7"); cyc(1, "R7");
    check("R7 peak 4095", out_val, 12'd4095);
    trig_pulse = 1; cyc(1, "R7"); trig_pulse = 0; cyc(1, "R7");
    check("R7 after peak", out_val, 12'd4094);
    // R8 saturation
    chan_en = 0; cyc(1, "R9"); chan_en = 1;
    mode = 2'b01; amp_code = 4'd11; base_val = 12'd4000;
    cyc(1, "R8"); cyc(1, "R8");
    check("R8 clamp", out_val, 12'd4095);
    // R10 latency of a base change
    mode = 2'b00; base_val = 12'd10; cyc(1, "R10");
    base_val = 12'd20;
    @(negedge clk);
    check("R10 before edge", out_val, 12'd10);
    cyc(1, "R10 after edge");
    check("R10 literal", out_val, 12'd20);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      chan_en    = ($urandom_range(0, 39) != 0);
      trig_en    = ($urandom_range(0, 9) != 0);
      trig_pulse = $urandom_range(0, 1);
      if ($urandom_range(0, 49) == 0) mode = 2'($urandom);
      if ($urandom_range(0, 29) == 0) amp_code = 4'($urandom);
      if ($urandom_range(0, 19) == 0)
        base_val = ($urandom_range(0, 3) == 0) ? 12'($urandom) : 12'($urandom_range(0, 200));
      cyc(1, "R10 random");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule